// File: doc/BRIEF.md
# Modular Multilevel Converter Arm Solver

This block is a fixed-step, fixed-point real-time model of one converter arm made of half-bridge cells connected in series. An external network solver supplies one arm current each step. The block applies that current to every cell, because all cells in an arm carry the same current. The gate pair of each cell is also sampled once per step. For each cell the block decides how the cell conducts. It then advances the capacitor voltage or the snubber voltage of that cell by one forward-Euler step and produces the cell's output voltage. The arm voltage, which is the sum of all cell outputs, is handed back to the network solver.

All cells share one arithmetic datapath with four pipeline stages, and one cell enters it per clock. A step begins with a one-cycle strobe that latches the current and every gate input. It ends with a one-cycle done pulse, after which every output of the step is valid. For N cells a step takes N+3 clock cycles. At 200 MHz the default arm fits comfortably inside a 1 µs step, and a full 64-cell arm takes 335 ns. The per-cell capacitor coefficient (step length over capacitance) is supplied as a static Q-format input with FRAC fractional bits. The snubber coefficient is a parameter. All updates saturate at the signed VW-bit limits.

Top module: `mmc_arm_solver`

## Requirements
- R1: After reset, every cell output, the arm voltage, the done pulse and the shoot-through flag are zero. All capacitor and snubber states also start at zero.
- R2: A gate pair {gate_hi[c], gate_lo[c]} of 2'b10 inserts the cell. The capacitor becomes sat(Vc + (I·Kc >>> FRAC)), where the product is rounded toward minus infinity by the arithmetic shift, and the cell output equals this new capacitor value.
- R3: A gate pair of 2'b01 bypasses the cell. Its output is 0 and its capacitor voltage is held.
- R4: A gate pair of 2'b11 is handled exactly like 2'b01. It also sets short_fault, which stays set until reset.
- R5: A gate pair of 2'b00 with I > 0 behaves in one of two ways. If the snubber voltage Vs is at least Vc, the capacitor charges as in R2, the output is the new Vc and Vs is loaded with that value. Otherwise Vs becomes sat(Vs + (I·SNUB_K >>> FRAC)), Vc is held and the output is the new Vs.
- R6: A gate pair of 2'b00 with I < 0 also behaves in one of two ways. If Vs ≤ 0, the output is 0, Vs is loaded with 0 and Vc is held. Otherwise Vs is integrated as in R5 with the negative current, Vc is held and the output is the new Vs.
- R7: A gate pair of 2'b00 with I = 0 holds both Vc and Vs, and the cell output equals Vs.
- R8: Every capacitor and snubber update clips to the range [-2^(VW-1), 2^(VW-1)-1] instead of wrapping.
- R9: When the done pulse is high, arm_voltage equals the sum of all cell_vout values of that step.
- R10: The done pulse is high for exactly one cycle, N_CELLS+3 rising edges after the edge that accepted step_start. It is never high at any other time.
- R11: While a step is in progress, step_start is ignored, as are changes on arm_current and on the gate inputs. A step uses only the values latched at its own start.
- R12: A cell outside the 2'b00 gate state keeps its snubber voltage unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_start | input | 1 | Strobe that begins a model step; latches current and gates |
| arm_current | input | IW | Signed arm current shared by all cells |
| gate_hi | input | N_CELLS | Upper switch gate of each cell |
| gate_lo | input | N_CELLS | Lower switch gate of each cell |
| cap_coef | input | N_CELLS*KW | Unsigned per-cell Euler coefficient, cell c at bits [c*KW +: KW] |
| cell_vout | output | N_CELLS*VW | Signed cell output voltages, cell c at bits [c*VW +: VW] |
| arm_voltage | output | VW+clog2(N_CELLS) | Signed sum of the cell outputs |
| step_done | output | 1 | One-cycle pulse when the last cell of a step is finished |
| short_fault | output | 1 | Sticky flag for a shoot-through gate pair |

## Verification
A wrong mode decision or a wrong update shows at that cell's output and in the arm sum on the very done pulse of the same step. A corrupted capacitor or snubber state does not always show at once. It stays hidden while the cell is bypassed, and it appears on the first later step that reads it: an insertion, a charge path or an idle high-impedance step. For that reason the bench runs long random sequences that mix all gate states and both current signs, so any stored-state error surfaces within a few steps. The position of the done pulse is compared on every clock, so an error in the sequencing shows in the cycle where it occurs.

// File: rtl/mmc_arm_pkg.sv
package mmc_arm_pkg;

    // Conduction state of one cell for one step
    typedef enum logic [2:0] {
        MD_ON      = 3'd0,  // inserted: capacitor in the current path
        MD_OFF     = 3'd1,  // bypassed: terminals shorted
        MD_SHORT   = 3'd2,  // both gates on: treated as bypass, flagged
        MD_HZ_CHG  = 3'd3,  // no gates, positive current through upper diode
        MD_HZ_BLKP = 3'd4,  // no gates, positive current into snubber
        MD_HZ_BYP  = 3'd5,  // no gates, negative current through lower diode
        MD_HZ_BLKN = 3'd6,  // no gates, negative current out of snubber
        MD_HZ_IDLE = 3'd7   // no gates, zero current
    } cell_mode_e;

    function automatic logic uses_cap(input cell_mode_e m);
        return (m == MD_ON) || (m == MD_HZ_CHG);
    endfunction

    function automatic logic uses_snub(input cell_mode_e m);
        return (m == MD_HZ_BLKP) || (m == MD_HZ_BLKN);
    endfunction

    function automatic logic is_hiz(input cell_mode_e m);
        return (m == MD_HZ_CHG) || (m == MD_HZ_BLKP) || (m == MD_HZ_BYP) ||
               (m == MD_HZ_BLKN) || (m == MD_HZ_IDLE);
    endfunction

    function automatic logic out_zero(input cell_mode_e m);
        return (m == MD_OFF) || (m == MD_SHORT) || (m == MD_HZ_BYP);
    endfunction

endpackage

// File: rtl/mmc_cell_decode.sv
module mmc_cell_decode
    import mmc_arm_pkg::*;
#(
    parameter int VW = 16,
    parameter int IW = 16
) (
    input  logic                 g_up,
    input  logic                 g_dn,
    input  logic signed [IW-1:0] cur,
    input  logic signed [VW-1:0] vc,
    input  logic signed [VW-1:0] vs,
    output cell_mode_e           mode
);

    logic cur_zero;
    logic cur_neg;
    logic vs_nonpos;

    always_comb begin
        cur_zero  = (cur == '0);
        cur_neg   = cur[IW-1];
        vs_nonpos = vs[VW-1] || (vs == '0);
    end

    always_comb begin
        unique case ({g_up, g_dn})
            2'b10:   mode = MD_ON;
            2'b01:   mode = MD_OFF;
            2'b11:   mode = MD_SHORT;
            default: begin
                if (cur_zero)
                    mode = MD_HZ_IDLE;
                else if (!cur_neg)
                    mode = (vs >= vc) ? MD_HZ_CHG : MD_HZ_BLKP;
                else
                    mode = vs_nonpos ? MD_HZ_BYP : MD_HZ_BLKN;
            end
        endcase
    end

endmodule

// File: rtl/mmc_step_seq.sv
module mmc_step_seq #(
    parameter int N_CELLS = 8,
    parameter int IDXW    = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_start,
    input  logic            fin_i,
    output logic            accept_o,
    output logic            issue_valid_o,
    output logic [IDXW-1:0] issue_idx_o
);

    localparam logic [IDXW-1:0] LAST = IDXW'(N_CELLS - 1);

    logic busy;

    assign accept_o = step_start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy          <= 1'b0;
            issue_valid_o <= 1'b0;
            issue_idx_o   <= '0;
        end else begin
            if (accept_o) begin
                busy          <= 1'b1;
                issue_valid_o <= 1'b1;
                issue_idx_o   <= '0;
            end else if (issue_valid_o) begin
                if (issue_idx_o == LAST)
                    issue_valid_o <= 1'b0;
                else
                    issue_idx_o <= issue_idx_o + 1'b1;
            end
            if (fin_i)
                busy <= 1'b0;
        end
    end

    // A running step stays running until its last cell completes
    p_busy_hold_r11: assert property (@(posedge clk) disable iff (rst)
        busy && !fin_i |=> busy);

    // Cells enter the datapath in ascending order, one per clock
    p_issue_order_r10: assert property (@(posedge clk) disable iff (rst)
        issue_valid_o && (issue_idx_o != LAST) |=>
            issue_valid_o && (issue_idx_o == $past(issue_idx_o) + 1'b1));

endmodule

// File: rtl/mmc_cell_update.sv
module mmc_cell_update
    import mmc_arm_pkg::*;
#(
    parameter int VW     = 16,
    parameter int IW     = 16,
    parameter int KW     = 16,
    parameter int FRAC   = 12,
    parameter int SNUB_K = 2048,
    parameter int IDXW   = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [IDXW-1:0]      in_idx,
    input  cell_mode_e           in_mode,
    input  logic signed [IW-1:0] in_cur,
    input  logic [KW-1:0]        in_k,
    input  logic signed [VW-1:0] in_vc,
    input  logic signed [VW-1:0] in_vs,
    output logic                 out_valid,
    output logic [IDXW-1:0]      out_idx,
    output cell_mode_e           out_mode,
    output logic signed [VW-1:0] out_vc,
    output logic signed [VW-1:0] out_vs,
    output logic signed [VW-1:0] out_vout
);

    localparam int PW = IW + KW + 1;
    localparam logic signed [PW-1:0] VMAX = {{(PW-VW+1){1'b0}}, {(VW-1){1'b1}}};
    localparam logic signed [PW-1:0] VMIN = {{(PW-VW+1){1'b1}}, {(VW-1){1'b0}}};
    localparam logic [KW-1:0] K_SNUB = KW'(SNUB_K);

    // ---- stage A: coefficient select and multiply ----
    typedef struct packed {
        logic                 valid;
        logic [IDXW-1:0]      idx;
        cell_mode_e           mode;
        logic signed [PW-1:0] prod;
        logic signed [VW-1:0] vc;
        logic signed [VW-1:0] vs;
    } mul_stage_t;

    mul_stage_t           sa;
    logic signed [PW-1:0] cur_x;
    logic signed [PW-1:0] k_x;
    logic [KW-1:0]        k_use;

    always_comb begin
        k_use = uses_cap(in_mode) ? in_k : K_SNUB;
        cur_x = {{(PW-IW){in_cur[IW-1]}}, in_cur};
        k_x   = {{(PW-KW){1'b0}}, k_use};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sa <= '0;
        end else begin
            sa.valid <= in_valid;
            sa.idx   <= in_idx;
            sa.mode  <= in_mode;
            sa.prod  <= cur_x * k_x;
            sa.vc    <= in_vc;
            sa.vs    <= in_vs;
        end
    end

    // ---- stage B: scale, accumulate, saturate, route ----
    logic signed [PW-1:0] incr;
    logic signed [PW-1:0] base_x;
    logic signed [PW-1:0] total;
    logic signed [VW-1:0] sum_sat;
    logic signed [VW-1:0] vc_nx;
    logic signed [VW-1:0] vs_nx;
    logic signed [VW-1:0] vo_nx;

    always_comb begin
        incr   = sa.prod >>> FRAC;
        base_x = uses_cap(sa.mode) ? {{(PW-VW){sa.vc[VW-1]}}, sa.vc}
                                   : {{(PW-VW){sa.vs[VW-1]}}, sa.vs};
        total  = base_x + incr;
        if (total > VMAX)
            sum_sat = VMAX[VW-1:0];
        else if (total < VMIN)
            sum_sat = VMIN[VW-1:0];
        else
            sum_sat = total[VW-1:0];
    end

    always_comb begin
        vc_nx = uses_cap(sa.mode) ? sum_sat : sa.vc;
        if (sa.mode == MD_HZ_CHG || uses_snub(sa.mode))
            vs_nx = sum_sat;
        else if (sa.mode == MD_HZ_BYP)
            vs_nx = '0;
        else
            vs_nx = sa.vs;
        if (out_zero(sa.mode))
            vo_nx = '0;
        else if (sa.mode == MD_HZ_IDLE)
            vo_nx = sa.vs;
        else
            vo_nx = sum_sat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_mode  <= MD_OFF;
            out_vc    <= '0;
            out_vs    <= '0;
            out_vout  <= '0;
        end else begin
            out_valid <= sa.valid;
            out_idx   <= sa.idx;
            out_mode  <= sa.mode;
            out_vc    <= vc_nx;
            out_vs    <= vs_nx;
            out_vout  <= vo_nx;
        end
    end

endmodule

// File: rtl/mmc_arm_solver.sv
module mmc_arm_solver
    import mmc_arm_pkg::*;
#(
    parameter int N_CELLS = 8,
    parameter int VW      = 16,
    parameter int IW      = 16,
    parameter int KW      = 16,
    parameter int FRAC    = 12,
    parameter int SNUB_K  = 2048,
    parameter int SW      = VW + $clog2(N_CELLS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step_start,
    input  logic signed [IW-1:0]    arm_current,
    input  logic [N_CELLS-1:0]      gate_hi,
    input  logic [N_CELLS-1:0]      gate_lo,
    input  logic [N_CELLS*KW-1:0]   cap_coef,
    output logic [N_CELLS*VW-1:0]   cell_vout,
    output logic signed [SW-1:0]    arm_voltage,
    output logic                    step_done,
    output logic                    short_fault
);

    localparam int IDXW = (N_CELLS > 1) ? $clog2(N_CELLS) : 1;
    localparam logic [IDXW-1:0] LAST = IDXW'(N_CELLS - 1);

    // ---- latched step inputs ----
    logic signed [IW-1:0] cur_q;
    logic [N_CELLS-1:0]   gh_q;
    logic [N_CELLS-1:0]   gl_q;

    // ---- per-cell state ----
    logic signed [VW-1:0] vc_mem [N_CELLS];
    logic signed [VW-1:0] vs_mem [N_CELLS];
    logic signed [VW-1:0] vout_r [N_CELLS];
    logic [KW-1:0]        coef_arr [N_CELLS];

    for (genvar c = 0; c < N_CELLS; c++) begin : g_cell_io
        assign coef_arr[c]            = cap_coef[c*KW +: KW];
        assign cell_vout[c*VW +: VW]  = vout_r[c];
    end

    // ---- sequencing ----
    logic            accept;
    logic            issue_valid;
    logic [IDXW-1:0] issue_idx;
    logic            fin;

    mmc_step_seq #(.N_CELLS(N_CELLS), .IDXW(IDXW)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .step_start   (step_start),
        .fin_i        (fin),
        .accept_o     (accept),
        .issue_valid_o(issue_valid),
        .issue_idx_o  (issue_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            gh_q  <= '0;
            gl_q  <= '0;
        end else if (accept) begin
            cur_q <= arm_current;
            gh_q  <= gate_hi;
            gl_q  <= gate_lo;
        end
    end

    // ---- stage 1: fetch and decode ----
    cell_mode_e dec_mode;

    mmc_cell_decode #(.VW(VW), .IW(IW)) u_dec (
        .g_up (gh_q[issue_idx]),
        .g_dn (gl_q[issue_idx]),
        .cur  (cur_q),
        .vc   (vc_mem[issue_idx]),
        .vs   (vs_mem[issue_idx]),
        .mode (dec_mode)
    );

    typedef struct packed {
        logic                 valid;
        logic [IDXW-1:0]      idx;
        cell_mode_e           mode;
        logic signed [IW-1:0] cur;
        logic [KW-1:0]        k;
        logic signed [VW-1:0] vc;
        logic signed [VW-1:0] vs;
    } issue_t;

    issue_t p1;

    always_ff @(posedge clk) begin
        if (rst) begin
            p1 <= '0;
        end else begin
            p1.valid <= issue_valid;
            p1.idx   <= issue_idx;
            p1.mode  <= dec_mode;
            p1.cur   <= cur_q;
            p1.k     <= coef_arr[issue_idx];
            p1.vc    <= vc_mem[issue_idx];
            p1.vs    <= vs_mem[issue_idx];
        end
    end

    // ---- stages 2 and 3: arithmetic ----
    logic                 o_valid;
    logic [IDXW-1:0]      o_idx;
    cell_mode_e           o_mode;
    logic signed [VW-1:0] o_vc;
    logic signed [VW-1:0] o_vs;
    logic signed [VW-1:0] o_vout;

    mmc_cell_update #(
        .VW(VW), .IW(IW), .KW(KW), .FRAC(FRAC), .SNUB_K(SNUB_K), .IDXW(IDXW)
    ) u_upd (
        .clk      (clk),
        .rst      (rst),
        .in_valid (p1.valid),
        .in_idx   (p1.idx),
        .in_mode  (p1.mode),
        .in_cur   (p1.cur),
        .in_k     (p1.k),
        .in_vc    (p1.vc),
        .in_vs    (p1.vs),
        .out_valid(o_valid),
        .out_idx  (o_idx),
        .out_mode (o_mode),
        .out_vc   (o_vc),
        .out_vs   (o_vs),
        .out_vout (o_vout)
    );

    // ---- stage 4: write back and accumulate ----
    logic signed [SW-1:0] acc;
    logic signed [SW-1:0] acc_base;
    logic signed [SW-1:0] vout_x;
    logic signed [SW-1:0] acc_next;

    assign fin = o_valid && (o_idx == LAST);

    always_comb begin
        vout_x   = {{(SW-VW){o_vout[VW-1]}}, o_vout};
        acc_base = (o_idx == '0) ? '0 : acc;
        acc_next = acc_base + vout_x;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_CELLS; i++) begin
                vc_mem[i] <= '0;
                vs_mem[i] <= '0;
                vout_r[i] <= '0;
            end
            acc         <= '0;
            arm_voltage <= '0;
            step_done   <= 1'b0;
            short_fault <= 1'b0;
        end else begin
            step_done <= 1'b0;
            if (o_valid) begin
                vc_mem[o_idx] <= o_vc;
                vs_mem[o_idx] <= o_vs;
                vout_r[o_idx] <= o_vout;
                acc           <= acc_next;
                if (o_mode == MD_SHORT)
                    short_fault <= 1'b1;
                if (o_idx == LAST) begin
                    arm_voltage <= acc_next;
                    step_done   <= 1'b1;
                end
            end
        end
    end

    // Capacitor untouched unless the mode routes current through it
    p_cap_hold_r3: assert property (@(posedge clk) disable iff (rst)
        o_valid && !uses_cap(o_mode) |-> o_vc == vc_mem[o_idx]);

    // Snubber untouched while the cell is gated
    p_snub_hold_r12: assert property (@(posedge clk) disable iff (rst)
        o_valid && !is_hiz(o_mode) |-> o_vs == vs_mem[o_idx]);

    // Shoot-through raises the flag on the next edge
    p_fault_set_r4: assert property (@(posedge clk) disable iff (rst)
        o_valid && (o_mode == MD_SHORT) |=> short_fault);

    // Flag stays set until reset
    p_fault_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        short_fault |=> short_fault);

    // Done lasts a single cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        step_done |=> !step_done);

endmodule

// File: tb/mmc_arm_solver_tb.sv
`timescale 1ns/1ps
module mmc_arm_solver_tb;

    localparam int N      = 8;
    localparam int VW     = 16;
    localparam int IW     = 16;
    localparam int KW     = 16;
    localparam int FRAC   = 12;
    localparam int SNUB_K = 2048;
    localparam int SW     = VW + $clog2(N);

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 step_start = 1'b0;
    logic signed [IW-1:0] arm_current = '0;
    logic [N-1:0]         gate_hi = '0;
    logic [N-1:0]         gate_lo = '0;
    logic [N*KW-1:0]      cap_coef;
    logic [N*VW-1:0]      cell_vout;
    logic signed [SW-1:0] arm_voltage;
    logic                 step_done;
    logic                 short_fault;

    always #2.5 clk = ~clk;

    mmc_arm_solver #(
        .N_CELLS(N), .VW(VW), .IW(IW), .KW(KW), .FRAC(FRAC), .SNUB_K(SNUB_K)
    ) u_dut (
        .clk(clk), .rst(rst), .step_start(step_start), .arm_current(arm_current),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .cap_coef(cap_coef),
        .cell_vout(cell_vout), .arm_voltage(arm_voltage),
        .step_done(step_done), .short_fault(short_fault)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // ---- behavioural reference ----
    longint r_vc  [N];
    longint r_vs  [N];
    longint r_out [N];
    string  r_tag [N];
    bit     r_fault = 1'b0;

    function automatic longint kcoef(input int c);
        return 64'(1024 + 256 * c);
    endfunction

    function automatic longint clip(input longint v, output bit hit);
        longint hi, lo;
        hi  = (64'sd1 <<< (VW - 1)) - 1;
        lo  = -(64'sd1 <<< (VW - 1));
        hit = 1'b0;
        if (v > hi) begin hit = 1'b1; return hi; end
        if (v < lo) begin hit = 1'b1; return lo; end
        return v;
    endfunction

    task automatic ref_step(input longint cur, input logic [N-1:0] gh, input logic [N-1:0] gl);
        for (int c = 0; c < N; c++) begin
            longint ci, si;
            bit     hit;
            ci  = (cur * kcoef(c)) >>> FRAC;
            si  = (cur * longint'(SNUB_K)) >>> FRAC;
            hit = 1'b0;
            if (gh[c] && !gl[c]) begin
                r_vc[c] = clip(r_vc[c] + ci, hit); r_out[c] = r_vc[c]; r_tag[c] = "R2";
            end else if (!gh[c] && gl[c]) begin
                r_out[c] = 0; r_tag[c] = "R3";
            end else if (gh[c] && gl[c]) begin
                r_out[c] = 0; r_fault = 1'b1; r_tag[c] = "R4";
            end else if (cur == 0) begin
                r_out[c] = r_vs[c]; r_tag[c] = "R7/R12";
            end else if (cur > 0) begin
                if (r_vs[c] >= r_vc[c]) begin
                    r_vc[c] = clip(r_vc[c] + ci, hit); r_vs[c] = r_vc[c];
                end else begin
                    r_vs[c] = clip(r_vs[c] + si, hit);
                end
                r_out[c] = (r_vs[c] == r_vc[c]) ? r_vc[c] : r_vs[c];
                r_tag[c] = "R5";
            end else begin
                if (r_vs[c] <= 0) begin
                    r_vs[c] = 0; r_out[c] = 0;
                end else begin
                    r_vs[c] = clip(r_vs[c] + si, hit); r_out[c] = r_vs[c];
                end
                r_tag[c] = "R6";
            end
            if (hit) r_tag[c] = "R8";
        end
    endtask

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        longint sum;
        sum = 0;
        for (int c = 0; c < N; c++) begin
            check(r_tag[c], longint'($signed(cell_vout[c*VW +: VW])), r_out[c]);
            sum += r_out[c];
        end
        check("R9", longint'(arm_voltage), sum);
        check("R4", longint'(short_fault), longint'(r_fault));
    endtask

    // One step with a late start pulse and scrambled inputs while busy (R11)
    task automatic run_step(input int cur, input logic [N-1:0] gh, input logic [N-1:0] gl);
        @(negedge clk);
        arm_current = IW'(cur);
        gate_hi     = gh;
        gate_lo     = gl;
        step_start  = 1'b1;
        ref_step(longint'(cur), gh, gl);
        @(negedge clk);
        step_start  = 1'b0;
        check("R10", longint'(step_done), 0);
        arm_current = IW'($urandom);
        gate_hi     = N'($urandom);
        gate_lo     = N'($urandom);
        for (int c = 1; c <= N + 3; c++) begin
            @(negedge clk);
            if (c == 1) step_start = 1'b1;   // R11: must be ignored
            if (c == 2) step_start = 1'b0;
            check("R10/R11", longint'(step_done), (c == N + 3) ? 1 : 0);
        end
        check_outputs();
    endtask

    initial begin
        for (int c = 0; c < N; c++) begin
            cap_coef[c*KW +: KW] = KW'(kcoef(c));
            r_vc[c] = 0; r_vs[c] = 0; r_out[c] = 0; r_tag[c] = "R1";
        end
        void'($urandom(7));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", longint'(step_done), 0);
        check("R1", longint'(short_fault), 0);
        check("R1", longint'(arm_voltage), 0);
        for (int c = 0; c < N; c++)
            check("R1", longint'($signed(cell_vout[c*VW +: VW])), 0);

        // R2: all inserted, charging
        repeat (3) run_step(4000, 8'hFF, 8'h00);
        // R3: bypass half, insert other half with negative current
        run_step(-3000, 8'h0F, 8'hF0);
        run_step(2500, 8'h00, 8'hFF);
        // R5: gates off, positive current: snubber blocks, then diode conducts
        repeat (6) run_step(6000, 8'h00, 8'h00);
        // R7/R12: zero current, then gated steps, then idle again
        run_step(0, 8'h00, 8'h00);
        run_step(3000, 8'hAA, 8'h55);
        run_step(0, 8'h00, 8'h00);
        // R6: gates off, negative current: snubber discharges, then bypass diode
        repeat (6) run_step(-7000, 8'h00, 8'h00);
        // R8: saturation at both rails
        repeat (4) run_step(30000, 8'hFF, 8'h00);
        repeat (8) run_step(-30000, 8'hFF, 8'h00);
        repeat (3) run_step(30000, 8'h00, 8'h00);
        // R4: shoot-through on two cells
        run_step(1500, 8'h81, 8'h83);
        // random mix, both current signs in every gate state
        for (int s = 0; s < 160; s++) begin
            int cur;
            cur = (s % 9 == 0) ? 0 : (int'($urandom_range(0, 24000)) - 12000);
            run_step(cur, N'($urandom), N'($urandom));
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule